// File: doc/BRIEF.md
# UART transmitter with flow control

This block is the transmit half of an asynchronous serial channel. A single holding register accepts a character from the host. A shift register turns it into a frame on the serial line, timed by a clock enable that pulses sixteen times per bit. The frame has a low start bit, 5 to 8 data bits sent LSB first, an optional parity bit, and a high stop period. The stop period is set in sixteenths of a bit, and its range depends on the character length. The character length, parity and stop settings are captured when a character moves from the holding register into the shift register.

Two flow-control features are available. With clear-to-send gating on, a character starts only while the remote side asserts its clear-to-send line. A change on that line during a frame does not affect the frame. With automatic request-to-send on, the request line drops one bit time after the transmitter has been disabled and has sent everything it held. The request line is raised by a pulse input. Without automatic control, the transmitter never changes it.

Top module: `uart_tx_fc`

## Requirements
- R1: A frame on `txd_o` is one low bit, then 5 + `char_len_i` data bits LSB first (`char_len_i` 0..3 gives 5..8 bits), then optional parity, then a high stop period. Every bit lasts 16 pulses of `tick16_i`, and the line idles high.
- R2: When `par_en_i` is 1, a parity bit follows the data. With `par_odd_i` 0 it makes the count of ones in the data and parity bit even; with `par_odd_i` 1 it makes that count odd. When `par_en_i` is 0, no parity bit is sent.
- R3: For 6- to 8-bit characters, the stop period lasts 9 + `stop_code_i` ticks for codes 0..7 and 17 + `stop_code_i` ticks for codes 8..15.
- R4: For 5-bit characters, the stop period lasts 17 + `stop_code_i` ticks for every code.
- R5: After reset, `txd_o` is 1, `tx_rdy_o` is 1, `tx_empty_o` is 1 and `rts_o` is 0. `tx_rdy_o` is 1 exactly when the holding register is empty. `tx_empty_o` is 1 exactly when both the holding and shift registers are empty.
- R6: A write (`wr_i` high for one clock) is ignored when `tx_en_i` is 0 or the holding register is full.
- R7: When `cts_en_i` is 1, a character does not start while `cts_i` is 0. `txd_o` stays high and the character waits in the holding register until `cts_i` is 1.
- R8: A change on `cts_i` while a frame is being shifted out does not alter or stop that frame.
- R9: If the next character is ready when a stop period ends, its start bit begins on the very tick that ends the stop period, with no idle gap.
- R10: When `rts_ctl_i` is 1, `tx_en_i` is 0 and the transmitter is empty, `rts_o` goes to 0 exactly 16 ticks after `tx_empty_o` rises. It stays 1 until then.
- R11: When `rts_ctl_i` is 0, the transmitter never clears `rts_o`. A `rts_set_i` pulse sets it to 1.
- R12: Clearing `tx_en_i` does not abort the transmitter. The characters already in the holding and shift registers are still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick16_i | input | 1 | enable pulse, 16 per bit time |
| wr_i | input | 1 | write strobe for the holding register |
| wdata_i | input | 8 | character to send |
| tx_en_i | input | 1 | transmitter enable |
| char_len_i | input | 2 | data bits minus 5 |
| par_en_i | input | 1 | parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_code_i | input | 4 | stop length code |
| cts_en_i | input | 1 | enables clear-to-send gating |
| cts_i | input | 1 | clear-to-send from the remote side, 1 = ready |
| rts_ctl_i | input | 1 | enables automatic request-to-send negation |
| rts_set_i | input | 1 | pulse that asserts request-to-send |
| txd_o | output | 1 | serial data out |
| rts_o | output | 1 | request-to-send, 1 = asserted |
| tx_rdy_o | output | 1 | holding register empty |
| tx_empty_o | output | 1 | holding and shift registers empty |

## Verification
A write is taken at the clock edge that samples it, so `tx_rdy_o` and `tx_empty_o` fall after that edge. From an idle line, the start bit appears one clock later. Every later change on `txd_o` happens at the edge that consumes a tick, and the stop period ends in the same edge where `tx_empty_o` rises or the next start bit falls. The bench drives the tick pulse just after a rising edge and counts ticks at falling edges. It samples each bit at tick 8 of its 16, and it counts stop ticks up to the first falling edge where the line is low or the transmitter reports empty, so the count is exact. The request-to-send check counts 16 ticks from the first falling edge where `tx_empty_o` is high. It expects `rts_o` to be still 1 when the sixteenth tick is seen and 0 one edge later.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // stop period in oversampling ticks; short codes are shorter only above 5 bits
  function automatic int unsigned stop_ticks(input int unsigned tpb,
                                             input logic [1:0] len_code,
                                             input logic [3:0] stop_code);
    if (!stop_code[3] && len_code != 2'd0) return tpb / 2 + 1 + int'(stop_code);
    return tpb + 1 + int'(stop_code);
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_en_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = wr_i && tx_en_i && !valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= wdata_i;
    end else if (take_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  a_r6_full_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !take_i |=> valid_q && $stable(data_q));

  a_r6_disabled_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q && !tx_en_i |=> !valid_q);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TPB    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_v_i,
  input  logic [DATA_W-1:0] hold_d_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [3:0]        stop_code_i,
  input  logic              cts_en_i,
  input  logic              cts_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              txd_o
);

  localparam int CNT_W = $clog2(2 * TPB + 1);
  localparam int NB_W  = $clog2(DATA_W + 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  stop_len_q, stop_len_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [NB_W-1:0]   idx_q, idx_d;
  logic [NB_W-1:0]   nbits_q, nbits_d;
  logic              par_en_q, par_en_d;
  logic              par_bit_q, par_bit_d;
  logic              txd_q, txd_d;

  logic              can_load, load;
  logic              bit_last, stop_last;
  logic [NB_W-1:0]   nbits_new;
  logic [DATA_W-1:0] mask;

  assign can_load  = hold_v_i && (!cts_en_i || cts_i);
  assign bit_last  = cnt_q == CNT_W'(TPB - 1);
  assign stop_last = cnt_q == stop_len_q - 1'b1;
  assign nbits_new = NB_W'(char_len_i) + NB_W'(5);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = i < int'(nbits_new);
  end

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    stop_len_d = stop_len_q;
    sh_d       = sh_q;
    idx_d      = idx_q;
    nbits_d    = nbits_q;
    par_en_d   = par_en_q;
    par_bit_d  = par_bit_q;
    load       = 1'b0;

    unique case (state_q)
      ST_IDLE: load = can_load;
      ST_START: if (tick_i) begin
        if (bit_last) begin
          state_d = ST_DATA;
          cnt_d   = '0;
          idx_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_DATA: if (tick_i) begin
        if (bit_last) begin
          cnt_d = '0;
          sh_d  = sh_q >> 1;
          if (idx_q == nbits_q - 1'b1) state_d = par_en_q ? ST_PAR : ST_STOP;
          else idx_d = idx_q + 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_PAR: if (tick_i) begin
        if (bit_last) begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_STOP: if (tick_i) begin
        if (stop_last) begin
          // chain straight into the next start bit when possible
          if (can_load) load = 1'b1;
          else state_d = ST_IDLE;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase

    if (load) begin
      state_d    = ST_START;
      cnt_d      = '0;
      idx_d      = '0;
      sh_d       = hold_d_i & mask;
      nbits_d    = nbits_new;
      par_en_d   = par_en_i;
      par_bit_d  = (^(hold_d_i & mask)) ^ par_odd_i;
      stop_len_d = CNT_W'(stop_ticks(TPB, char_len_i, stop_code_i));
    end

    unique case (state_d)
      ST_START: txd_d = 1'b0;
      ST_DATA:  txd_d = sh_d[0];
      ST_PAR:   txd_d = par_bit_d;
      default:  txd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      stop_len_q <= CNT_W'(TPB + 1);
      sh_q       <= '0;
      idx_q      <= '0;
      nbits_q    <= NB_W'(5);
      par_en_q   <= 1'b0;
      par_bit_q  <= 1'b0;
      txd_q      <= 1'b1;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      stop_len_q <= stop_len_d;
      sh_q       <= sh_d;
      idx_q      <= idx_d;
      nbits_q    <= nbits_d;
      par_en_q   <= par_en_d;
      par_bit_q  <= par_bit_d;
      txd_q      <= txd_d;
    end
  end

  assign take_o = load;
  assign busy_o = state_q != ST_IDLE;
  assign txd_o  = txd_q;

  a_r1_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_START |-> txd_q == 1'b0);

  a_r3_stop_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STOP |-> cnt_q < stop_len_q);

  a_r8_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE && state_q != ST_STOP |=> state_q != ST_IDLE);

endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts #(
  parameter int TPB = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic set_i,
  input  logic ctl_i,
  input  logic tx_en_i,
  input  logic drained_i,
  output logic rts_o
);

  localparam int CW = $clog2(TPB);

  logic          rts_q;
  logic [CW-1:0] cnt_q;
  logic          armed;

  assign armed = ctl_i && !tx_en_i && drained_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (!armed) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;

      if (set_i) rts_q <= 1'b1;
      else if (armed && tick_i && cnt_q == CW'(TPB - 1)) rts_q <= 1'b0;
    end
  end

  assign rts_o = rts_q;

  a_r10_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rts_q) |-> $past(ctl_i && !tx_en_i && drained_i && tick_i));

  a_r11_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i |=> !$fell(rts_q));

endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
  parameter int DATA_W = 8,
  parameter int TPB    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_en_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [3:0]        stop_code_i,
  input  logic              cts_en_i,
  input  logic              cts_i,
  input  logic              rts_ctl_i,
  input  logic              rts_set_i,
  output logic              txd_o,
  output logic              rts_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o
);

  logic              hold_v;
  logic [DATA_W-1:0] hold_d;
  logic              take;
  logic              busy;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .tx_en_i (tx_en_i),
    .take_i  (take),
    .valid_o (hold_v),
    .data_o  (hold_d)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .TPB(TPB)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick16_i),
    .hold_v_i    (hold_v),
    .hold_d_i    (hold_d),
    .char_len_i  (char_len_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .stop_code_i (stop_code_i),
    .cts_en_i    (cts_en_i),
    .cts_i       (cts_i),
    .take_o      (take),
    .busy_o      (busy),
    .txd_o       (txd_o)
  );

  assign tx_rdy_o   = !hold_v;
  assign tx_empty_o = !hold_v && !busy;

  uart_tx_rts #(.TPB(TPB)) u_rts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .set_i     (rts_set_i),
    .ctl_i     (rts_ctl_i),
    .tx_en_i   (tx_en_i),
    .drained_i (tx_empty_o),
    .rts_o     (rts_o)
  );

  a_r5_empty_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_rdy_o);

  a_r7_cts_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cts_en_i |-> cts_i);

  a_r12_drain_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_v && !tx_en_i && !cts_en_i |=> !tx_empty_o);

endmodule

// File: tb/uart_tx_fc_tb.sv
`timescale 1ns/1ps
module uart_tx_fc_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick16_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       tx_en_i = 1'b0;
  logic [1:0] char_len_i = '0;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic [3:0] stop_code_i = '0;
  logic       cts_en_i = 1'b0;
  logic       cts_i = 1'b0;
  logic       rts_ctl_i = 1'b0;
  logic       rts_set_i = 1'b0;
  logic       txd_o, rts_o, tx_rdy_o, tx_empty_o;

  uart_tx_fc u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick16_i(tick16_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .tx_en_i(tx_en_i), .char_len_i(char_len_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .stop_code_i(stop_code_i),
    .cts_en_i(cts_en_i), .cts_i(cts_i), .rts_ctl_i(rts_ctl_i),
    .rts_set_i(rts_set_i), .txd_o(txd_o), .rts_o(rts_o),
    .tx_rdy_o(tx_rdy_o), .tx_empty_o(tx_empty_o)
  );

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [7:0] d;
    int         nb;
    bit         pe;
    bit         po;
    int         stop;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   mc      = 0;
  bit   done    = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // tick: one clock in four, changed just after a rising edge
  initial begin
    forever begin
      repeat (3) @(posedge clk_i);
      #1 tick16_i = 1'b1;
      @(posedge clk_i);
      #1 tick16_i = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  function automatic int stop_exp(input int nb, input int code);
    if (code < 8 && nb >= 6) return 9 + code;
    return 17 + code;
  endfunction

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  // driver: waits for room, records the expected frame, pulses the write
  task automatic send(input logic [7:0] d);
    exp_t e;
    while (tx_rdy_o !== 1'b1) @(negedge clk_i);
    step();
    e.nb   = 5 + int'(char_len_i);
    e.d    = d & 8'((1 << e.nb) - 1);
    e.pe   = par_en_i;
    e.po   = par_odd_i;
    e.stop = stop_exp(e.nb, int'(stop_code_i));
    q.push_back(e);
    wr_i = 1'b1;
    wdata_i = d;
    step();
    wr_i = 1'b0;
  endtask

  task automatic wait_empty();
    @(negedge clk_i);
    while (tx_empty_o !== 1'b1) @(negedge clk_i);
  endtask

  task automatic adv_to(input int target);
    while (mc < target) begin
      @(negedge clk_i);
      if (tick16_i) mc++;
    end
  endtask

  // monitor: decode each frame and compare against the head of the queue
  initial begin
    bit         chained;
    exp_t       e;
    logic [7:0] rx;
    int         s, nbt;
    chained = 0;
    wait (rst_ni === 1'b1);
    forever begin
      if (!chained) begin
        @(negedge clk_i);
        while (txd_o !== 1'b0) @(negedge clk_i);
      end
      chained = 0;
      mc = tick16_i ? 1 : 0;
      if (q.size() == 0) begin
        chk(0, "R1 unexpected frame", 0, 1);
        while (txd_o !== 1'b1) @(negedge clk_i);
        continue;
      end
      e = q.pop_front();
      adv_to(8);
      chk(txd_o == 1'b0, "R1 start bit", int'(txd_o), 0);
      rx = '0;
      for (int k = 0; k < e.nb; k++) begin
        adv_to(16 * (k + 1) + 8);
        rx[k] = txd_o;
      end
      chk(rx == e.d, "R1 data bits LSB first", int'(rx), int'(e.d));
      nbt = e.nb;
      if (e.pe) begin
        adv_to(16 * (e.nb + 1) + 8);
        chk(txd_o == ((^e.d) ^ e.po), "R2 parity bit", int'(txd_o), int'((^e.d) ^ e.po));
        nbt++;
      end
      adv_to(16 * (1 + nbt));
      s = 0;
      forever begin
        @(negedge clk_i);
        if (txd_o === 1'b0) begin
          chained = 1;
          break;
        end
        if (tx_empty_o === 1'b1) break;
        if (tick16_i) s++;
        if (s > e.stop) break;
      end
      if (e.nb == 5) chk(s == e.stop, "R4 stop ticks, 5-bit", s, e.stop);
      else chk(s == e.stop, "R3 stop ticks", s, e.stop);
      if (chained) chk(s == e.stop, "R9 next start follows stop", s, e.stop);
    end
  end

  initial begin
    int held_bad;
    int t;
    repeat (5) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(txd_o == 1'b1, "R5 reset txd", int'(txd_o), 1);
    chk(tx_rdy_o == 1'b1, "R5 reset ready", int'(tx_rdy_o), 1);
    chk(tx_empty_o == 1'b1, "R5 reset empty", int'(tx_empty_o), 1);
    chk(rts_o == 1'b0, "R5 reset rts", int'(rts_o), 0);

    // R6: write with transmitter disabled
    step();
    wr_i = 1'b1;
    wdata_i = 8'h3C;
    step();
    wr_i = 1'b0;
    held_bad = 0;
    repeat (200) begin
      @(negedge clk_i);
      if (txd_o !== 1'b1 || tx_rdy_o !== 1'b1 || tx_empty_o !== 1'b1) held_bad++;
    end
    chk(held_bad == 0, "R6 write ignored while disabled", held_bad, 0);

    // R1..R4 sweep over length, parity and stop code
    tx_en_i = 1'b1;
    for (int len = 0; len < 4; len++) begin
      for (int pm = 0; pm < 3; pm++) begin
        wait_empty();
        step();
        char_len_i  = 2'(len);
        par_en_i    = pm != 0;
        par_odd_i   = pm == 2;
        stop_code_i = 4'((len * 5 + pm * 3 + 1) % 16);
        send(8'(8'hA5 ^ (len * 37 + pm * 11)));
      end
    end

    // R3/R4/R9 stop corners, two characters back to back each
    for (int li = 0; li < 2; li++) begin
      for (int ci = 0; ci < 4; ci++) begin
        wait_empty();
        step();
        char_len_i  = li == 0 ? 2'd0 : 2'd3;
        par_en_i    = ci[0];
        par_odd_i   = ci[1];
        stop_code_i = ci == 0 ? 4'd0 : ci == 1 ? 4'd7 : ci == 2 ? 4'd8 : 4'd15;
        send(8'(8'h5E + li * 16 + ci));
        send(8'(8'hC3 - li * 8 - ci));
      end
    end

    // R6/R5: write while holding register full
    wait_empty();
    step();
    char_len_i = 2'd3;
    par_en_i = 1'b0;
    stop_code_i = 4'd7;
    send(8'h81);
    send(8'h7E);
    step();
    chk(tx_rdy_o == 1'b0, "R5 ready low while holding full", int'(tx_rdy_o), 0);
    chk(tx_empty_o == 1'b0, "R5 empty low while busy", int'(tx_empty_o), 0);
    wr_i = 1'b1;
    wdata_i = 8'hFF;
    step();
    wr_i = 1'b0;
    wait_empty();
    chk(q.size() == 0, "R6 extra write dropped", q.size(), 0);

    // R7: held by CTS
    step();
    cts_en_i = 1'b1;
    cts_i = 1'b0;
    send(8'h96);
    held_bad = 0;
    repeat (300) begin
      @(negedge clk_i);
      if (txd_o !== 1'b1 || tx_rdy_o !== 1'b0 || tx_empty_o !== 1'b0) held_bad++;
    end
    chk(held_bad == 0, "R7 character held while CTS low", held_bad, 0);
    step();
    cts_i = 1'b1;
    wait_empty();
    chk(q.size() == 0, "R7 character sent after CTS", q.size(), 0);

    // R8: CTS drops mid-frame
    step();
    par_en_i = 1'b1;
    send(8'h4B);
    @(negedge clk_i);
    while (txd_o !== 1'b0) @(negedge clk_i);
    repeat (60) @(negedge clk_i);
    step();
    cts_i = 1'b0;
    wait_empty();
    chk(q.size() == 0, "R8 frame completes despite CTS drop", q.size(), 0);
    send(8'h2D);
    held_bad = 0;
    repeat (200) begin
      @(negedge clk_i);
      if (txd_o !== 1'b1) held_bad++;
    end
    chk(held_bad == 0, "R7 next character waits for CTS", held_bad, 0);
    step();
    cts_i = 1'b1;
    wait_empty();
    step();
    cts_en_i = 1'b0;

    // R10/R12: disable with two characters queued, RTS auto negation
    rts_set_i = 1'b1;
    step();
    rts_set_i = 1'b0;
    rts_ctl_i = 1'b1;
    chk(rts_o == 1'b1, "R11 set pulse asserts rts", int'(rts_o), 1);
    send(8'hE1);
    send(8'h1E);
    tx_en_i = 1'b0;
    wait_empty();
    chk(q.size() == 0, "R12 queued characters drained", q.size(), 0);
    chk(rts_o == 1'b1, "R10 rts held until drained", int'(rts_o), 1);
    t = 0;
    while (t < 16) begin
      @(negedge clk_i);
      if (tick16_i) t++;
    end
    chk(rts_o == 1'b1, "R10 rts still high at 16th tick", int'(rts_o), 1);
    @(negedge clk_i);
    chk(rts_o == 1'b0, "R10 rts negated one bit after drain", int'(rts_o), 0);

    // R11: no automatic control
    step();
    rts_ctl_i = 1'b0;
    rts_set_i = 1'b1;
    step();
    rts_set_i = 1'b0;
    tx_en_i = 1'b1;
    send(8'h66);
    tx_en_i = 1'b0;
    wait_empty();
    t = 0;
    while (t < 48) begin
      @(negedge clk_i);
      if (tick16_i) t++;
    end
    @(negedge clk_i);
    chk(rts_o == 1'b1, "R11 rts untouched without control", int'(rts_o), 1);
    chk(q.size() == 0, "R1 all frames observed", q.size(), 0);
    finish_run();
  end

endmodule